// File: doc/BRIEF.md
# Ping-Pong Serial Shift-Out Engine

This block turns the contents of two 16-bit holding registers into a serial bit stream on a single data output, together with a shift clock that it generates itself. The two holding registers act as ping-pong buffers. Software-side logic refills one register while the other is being sent. Each register is written from a shared 16-bit data input while its own load strobe is high. The engine sends a whole register, then the other one, and then returns to the first. If nothing new has been written, it sends the old contents again.

All timing comes from a single-cycle enable strobe, `tick`, which an external divider supplies. Each half period of the shift clock lasts one tick. The data output changes when the shift clock falls, so a receiver can sample it on the rising edge.

There are two clocking modes. In free-running mode the clock toggles on every tick, even when no data is moving. Clearing the shift enable lets the current register finish before the engine stops. In fixed-count mode a programmed number of bits is sent. The clock then rests at a selectable level and the last bit stays on the output. The order of bits within a word, the mode, the count and the rest level are captured when shifting starts.

The sequencer has four states. `ST_IDLE` means nothing is moving. `ST_RUN` means bits are being shifted. `ST_DRAIN` means free-running mode is finishing the current register after enable was cleared. `ST_HOLD` means a fixed count has finished and the engine waits for enable to drop. The transitions are:
- start: `ST_IDLE` to `ST_RUN`, on a tick with enable set and a valid start condition.
- count done: `ST_RUN` to `ST_HOLD`, on the falling tick after the last counted bit.
- drain: `ST_RUN` to `ST_DRAIN`, when enable is cleared in free-running mode.
- word-end stop: `ST_RUN` or `ST_DRAIN` to `ST_IDLE`, on the falling tick of the last bit of a word in free-running mode with enable cleared.
- release: `ST_HOLD` to `ST_IDLE`, when enable is low.

Top module: `pingpong_shifter`

## Requirements
- R1: While `load_a` (or `load_b`) is high, holding register A (or B) copies `data_in` on every clock. The copied value is sent the next time that register's word starts.
- R2: Shifting starts with bit 0 of register A when `msb_first`=0, and with bit 15 of register A when `msb_first`=1. Later bits of the word follow in that same direction.
- R3: Words are sent in the order A, B, A, B and so on. A register that has not been reloaded is sent again with its previous contents.
- R4: `sclk` changes only on the clock after a cycle with `tick`=1. While busy, `sdo` changes only when `sclk` falls, so every bit is stable at the rising edge of `sclk`.
- R5: In free-running mode (`fixed_mode`=0) `sclk` toggles on every tick, including while the engine is not busy. Shifting starts on a tick when `sclk` is high.
- R6: In free-running mode, clearing `shift_en` lets the engine finish the current register and then stop. The next start begins again at the first bit of register A.
- R7: In fixed-count mode (`fixed_mode`=1), exactly `bit_count` rising edges of `sclk` carry data. After the last one, `sdo` keeps the last bit. Clearing `shift_en` does not cut the count short. No new transfer starts until `shift_en` has been low.
- R8: After a fixed count completes, and while the engine is idle in fixed-count mode, `sclk` rests at `park_high` (1 for high, 0 for low).
- R9: In fixed-count mode a `bit_count` of 0 starts nothing: `busy` stays low, no bit is sent and `sclk` stays at its rest level.
- R10: A load of a register while its word is being sent does not change the bits of that word. It takes effect on that register's next word.
- R11: `busy` is high from the start tick until the engine stops, in either mode. While `busy` is low, `sdo` does not change.
- R12: After reset, `sdo`=0, `sclk`=0, `busy`=0 and both holding registers are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick | input | 1 | Single-cycle enable from the divider; one shift-clock half period |
| data_in | input | 16 | Word written into a holding register |
| load_a | input | 1 | Load strobe for holding register A |
| load_b | input | 1 | Load strobe for holding register B |
| shift_en | input | 1 | Starts shifting; clearing it stops a free-running transfer |
| msb_first | input | 1 | 1 sends bit 15 first, 0 sends bit 0 first |
| fixed_mode | input | 1 | 1 selects fixed-count mode, 0 selects free-running mode |
| bit_count | input | 8 | Number of bits in fixed-count mode |
| park_high | input | 1 | Rest level of the shift clock in fixed-count mode |
| sdo | output | 1 | Serial data output |
| sclk | output | 1 | Generated shift clock |
| busy | output | 1 | High while a transfer is in progress |

## Verification
The checker runs on every cycle and covers the timing rules. It checks that the clock moves only after a tick. It checks that data changes only on a falling clock edge while busy, and that data stays still while not busy. It checks that the idle clock toggles in free-running mode and rests at the selected level in fixed-count mode. It also checks that a zero count never raises busy. The bench scenarios show what a single-cycle property cannot:
- the order of bits across both words and their wrap-around;
- the exact number of bits in a fixed transfer;
- a drain that ends at a word boundary;
- a reload in the middle of a word that only appears on that register's next pass.

// File: rtl/sh_pkg.sv
package sh_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_RUN   = 2'd1,
        ST_DRAIN = 2'd2,
        ST_HOLD  = 2'd3
    } sh_state_e;

endpackage

// File: rtl/sh_shadow_bank.sv
module sh_shadow_bank #(
    parameter int WORD_W = 16,
    parameter int NBUF   = 2
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [WORD_W-1:0]            data_in,
    input  logic [NBUF-1:0]              load,
    output logic [NBUF-1:0][WORD_W-1:0]  regs
);

    // One holding register per buffer, each with its own load strobe.
    for (genvar g = 0; g < NBUF; g++) begin : g_buf
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                regs[g] <= '0;
            end else if (load[g]) begin
                regs[g] <= data_in;
            end
        end
    end

endmodule

// File: rtl/sh_bit_pick.sv
module sh_bit_pick #(
    parameter int WORD_W = 16,
    localparam int IDX_W = $clog2(WORD_W)
) (
    input  logic [WORD_W-1:0] word,
    input  logic [IDX_W-1:0]  idx,
    input  logic              msb_first,
    output logic              bit_out
);

    logic [WORD_W-1:0] rev;

    // Reversed copy of the word, so that both orders use the same index.
    for (genvar g = 0; g < WORD_W; g++) begin : g_rev
        assign rev[g] = word[WORD_W-1-g];
    end

    always_comb begin
        if (msb_first) begin
            bit_out = rev[idx];
        end else begin
            bit_out = word[idx];
        end
    end

endmodule

// File: rtl/pingpong_shifter.sv
module pingpong_shifter
    import sh_pkg::*;
#(
    parameter int WORD_W = 16,
    parameter int CNT_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic [WORD_W-1:0] data_in,
    input  logic              load_a,
    input  logic              load_b,
    input  logic              shift_en,
    input  logic              msb_first,
    input  logic              fixed_mode,
    input  logic [CNT_W-1:0]  bit_count,
    input  logic              park_high,
    output logic              sdo,
    output logic              sclk,
    output logic              busy
);

    localparam int                NBUF     = 2;
    localparam int                IDX_W    = $clog2(WORD_W);
    localparam logic [IDX_W-1:0]  LAST_IDX = IDX_W'(WORD_W - 1);

    // ---------------- holding registers ----------------
    logic [NBUF-1:0][WORD_W-1:0] shadow;

    sh_shadow_bank #(
        .WORD_W (WORD_W),
        .NBUF   (NBUF)
    ) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .data_in (data_in),
        .load    ({load_b, load_a}),
        .regs    (shadow)
    );

    // ---------------- state and datapath registers ----------------
    sh_state_e         state, state_nx;
    logic              sclk_q;
    logic              sdo_q;
    logic              sel;
    logic [IDX_W-1:0]  idx;
    logic [WORD_W-1:0] word;
    logic [CNT_W-1:0]  cnt_done;
    logic [CNT_W-1:0]  cnt_l;
    logic              fixed_l;
    logic              msb_l;
    logic              park_l;

    // ---------------- decode ----------------
    logic shifting;
    logic fall_tick;
    logic rise_tick;
    logic word_end;
    logic count_hit;
    logic free_stop;
    logic start_ok;
    logic do_start;
    logic stop_now;
    logic advance;

    always_comb begin
        shifting  = (state == ST_RUN) || (state == ST_DRAIN);
        fall_tick = tick && sclk_q;
        rise_tick = tick && !sclk_q;
        word_end  = (idx == LAST_IDX);
        count_hit = fixed_l && (cnt_done == cnt_l);
        free_stop = !fixed_l && !shift_en;
        start_ok  = shift_en && (fixed_mode ? (bit_count != '0) : sclk_q);
    end

    // ---------------- next state ----------------
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (tick && start_ok) begin
                    state_nx = ST_RUN;
                end
            end
            ST_RUN: begin
                if (fall_tick && count_hit) begin
                    state_nx = ST_HOLD;
                end else if (fall_tick && word_end && free_stop) begin
                    state_nx = ST_IDLE;
                end else if (free_stop) begin
                    state_nx = ST_DRAIN;
                end
            end
            ST_DRAIN: begin
                if (fall_tick && word_end) begin
                    state_nx = ST_IDLE;
                end
            end
            ST_HOLD: begin
                if (!shift_en) begin
                    state_nx = ST_IDLE;
                end
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    always_comb begin
        do_start = (state == ST_IDLE) && (state_nx == ST_RUN);
        stop_now = shifting && ((state_nx == ST_IDLE) || (state_nx == ST_HOLD));
        advance  = shifting && fall_tick && !stop_now;
    end

    // ---------------- state register ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    // ---------------- next bit selection ----------------
    logic [IDX_W-1:0]  pick_idx;
    logic [WORD_W-1:0] pick_word;
    logic              pick_msb;
    logic              pick_bit;

    always_comb begin
        if (state == ST_IDLE) begin
            pick_word = shadow[0];
            pick_idx  = '0;
            pick_msb  = msb_first;
        end else begin
            pick_word = word_end ? shadow[sel ^ 1'b1] : word;
            pick_idx  = word_end ? '0 : idx + 1'b1;
            pick_msb  = msb_l;
        end
    end

    sh_bit_pick #(
        .WORD_W (WORD_W)
    ) u_pick (
        .word      (pick_word),
        .idx       (pick_idx),
        .msb_first (pick_msb),
        .bit_out   (pick_bit)
    );

    // ---------------- outputs and datapath ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk_q   <= 1'b0;
            sdo_q    <= 1'b0;
            sel      <= 1'b0;
            idx      <= '0;
            word     <= '0;
            cnt_done <= '0;
            cnt_l    <= '0;
            fixed_l  <= 1'b0;
            msb_l    <= 1'b0;
            park_l   <= 1'b0;
        end else begin
            // shift clock
            if (tick) begin
                if (!shifting) begin
                    if (do_start) begin
                        sclk_q <= 1'b0;
                    end else if (fixed_mode) begin
                        sclk_q <= park_high;
                    end else begin
                        sclk_q <= ~sclk_q;
                    end
                end else if (!sclk_q) begin
                    sclk_q <= 1'b1;
                end else if (state_nx == ST_HOLD) begin
                    sclk_q <= park_l;
                end else begin
                    sclk_q <= 1'b0;
                end
            end

            // bit counter for fixed-count transfers
            if (do_start) begin
                cnt_done <= '0;
            end else if (shifting && rise_tick) begin
                cnt_done <= cnt_done + 1'b1;
            end

            // configuration captured at start
            if (do_start) begin
                cnt_l   <= bit_count;
                fixed_l <= fixed_mode;
                msb_l   <= msb_first;
                park_l  <= park_high;
            end

            // word, index and buffer select
            if (do_start) begin
                sel   <= 1'b0;
                idx   <= '0;
                word  <= shadow[0];
                sdo_q <= pick_bit;
            end else if (advance) begin
                idx   <= pick_idx;
                sdo_q <= pick_bit;
                if (word_end) begin
                    sel  <= sel ^ 1'b1;
                    word <= shadow[sel ^ 1'b1];
                end
            end else if (stop_now && (state_nx == ST_IDLE)) begin
                sel <= 1'b0;
                idx <= '0;
            end
        end
    end

    assign sclk = sclk_q;
    assign sdo  = sdo_q;
    assign busy = shifting;

endmodule

// File: rtl/pingpong_shifter_chk.sv
module pingpong_shifter_chk #(
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tick,
    input logic             fixed_mode,
    input logic [CNT_W-1:0] bit_count,
    input logic             park_high,
    input logic             sdo,
    input logic             sclk,
    input logic             busy
);

    // R4
    sclk_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(tick) |-> $stable(sclk));

    // R4
    sdo_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy) && !$stable(sdo)) |-> (!sclk && $past(sclk)));

    // R11
    sdo_quiet_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && $past(!busy)) |-> $stable(sdo));

    // R5
    free_idle_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && $past(!busy) && $past(tick) && $past(!fixed_mode)) |-> (sclk != $past(sclk)));

    // R8
    park_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && $past(!busy) && $past(tick) && $past(fixed_mode)) |-> (sclk == $past(park_high)));

    // R9
    zero_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fixed_mode && (bit_count == '0) && !busy) |=> !busy);

endmodule

bind pingpong_shifter pingpong_shifter_chk #(
    .CNT_W (CNT_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick       (tick),
    .fixed_mode (fixed_mode),
    .bit_count  (bit_count),
    .park_high  (park_high),
    .sdo        (sdo),
    .sclk       (sclk),
    .busy       (busy)
);

// File: tb/pingpong_shifter_test.sv
`timescale 1ns/1ps
module pingpong_shifter_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic [15:0] data_in = '0;
    logic        load_a = 1'b0;
    logic        load_b = 1'b0;
    logic        shift_en = 1'b0;
    logic        msb_first = 1'b0;
    logic        fixed_mode = 1'b1;
    logic [7:0]  bit_count = '0;
    logic        park_high = 1'b0;
    logic        sdo;
    logic        sclk;
    logic        busy;

    int checks = 0;
    int errs = 0;

    pingpong_shifter uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tick),
        .data_in    (data_in),
        .load_a     (load_a),
        .load_b     (load_b),
        .shift_en   (shift_en),
        .msb_first  (msb_first),
        .fixed_mode (fixed_mode),
        .bit_count  (bit_count),
        .park_high  (park_high),
        .sdo        (sdo),
        .sclk       (sclk),
        .busy       (busy)
    );

    always #4 clk = ~clk;

    // tick on every other clock
    always @(posedge clk) tick <= ~tick;

    // ---------------- monitor ----------------
    logic cap [0:255];
    int   cap_n = 0;
    int   rises = 0;
    int   busy_seen = 0;
    int   tick_viol = 0;
    int   sdo_viol = 0;
    logic sclk_prev = 1'b0;
    logic sdo_prev = 1'b0;
    logic tick_prev = 1'b0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (sclk && !sclk_prev) begin
                rises++;
                if (busy) begin
                    if (cap_n < 256) cap[cap_n] = sdo;
                    cap_n++;
                end
            end
            if (busy) busy_seen = 1;
            if ((sclk != sclk_prev) && !tick_prev) tick_viol++;
            if (busy && (sdo != sdo_prev) && sclk) sdo_viol++;
        end
        sclk_prev = sclk;
        sdo_prev  = sdo;
        tick_prev = tick;
    end

    // ---------------- helpers ----------------
    task automatic check_eq(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errs++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic logic exp_bit(input int k, input logic [15:0] a,
                                     input logic [15:0] b, input logic msb);
        logic [15:0] w;
        int p;
        w = (((k / 16) % 2) == 0) ? a : b;
        p = k % 16;
        return msb ? w[15 - p] : w[p];
    endfunction

    task automatic check_bits(input string tag, input int first, input int n,
                              input logic [15:0] a, input logic [15:0] b, input logic msb);
        int bad = 0;
        int bad_k = -1;
        for (int k = first; k < first + n; k++) begin
            if (cap[k] !== exp_bit(k, a, b, msb)) begin
                bad++;
                if (bad_k < 0) bad_k = k;
            end
        end
        checks++;
        if (bad != 0) begin
            errs++;
            $display("FAIL %s bit %0d actual=%0d expected=%0d", tag, bad_k,
                     cap[bad_k], exp_bit(bad_k, a, b, msb));
        end
    endtask

    task automatic load_word(input logic which_b, input logic [15:0] v);
        @(negedge clk);
        data_in = v;
        load_a = !which_b;
        load_b = which_b;
        @(negedge clk);
        load_a = 1'b0;
        load_b = 1'b0;
    endtask

    task automatic wait_done(input int limit);
        int seen = 0;
        for (int i = 0; i < limit; i++) begin
            @(negedge clk);
            if (seen && !busy) break;
            if (busy) seen = 1;
        end
    endtask

    task automatic start(input logic fixed, input logic msb, input logic park, input int cnt);
        @(negedge clk);
        fixed_mode = fixed;
        msb_first  = msb;
        park_high  = park;
        bit_count  = 8'(cnt);
        cap_n      = 0;
        busy_seen  = 0;
        shift_en   = 1'b1;
    endtask

    task automatic release_en();
        @(negedge clk);
        shift_en = 1'b0;
        repeat (6) @(negedge clk);
    endtask

    // ---------------- scenarios ----------------
    task automatic t_reset();
        check_eq("R12 sdo after reset", int'(sdo), 0);
        check_eq("R12 sclk after reset", int'(sclk), 0);
        check_eq("R12 busy after reset", int'(busy), 0);
    endtask

    task automatic t_fixed_lsb();
        int n_after;
        load_word(1'b0, 16'hA5C3);
        load_word(1'b1, 16'h0F0F);
        start(1'b1, 1'b0, 1'b0, 20);
        wait_done(2000);
        check_eq("R11 busy seen during fixed run", busy_seen, 1);
        check_eq("R7 bit count 20", cap_n, 20);
        check_bits("R2 R3 lsb-first A then B", 0, 20, 16'hA5C3, 16'h0F0F, 1'b0);
        check_eq("R1 loaded word sent", int'(cap[0]), 1);
        check_eq("R7 last bit persists", int'(sdo), int'(exp_bit(19, 16'hA5C3, 16'h0F0F, 1'b0)));
        check_eq("R8 park low", int'(sclk), 0);
        n_after = cap_n;
        repeat (20) @(negedge clk);
        check_eq("R7 no restart while enable high", cap_n, n_after);
        check_eq("R11 busy low after count", int'(busy), 0);
        release_en();
    endtask

    task automatic t_fixed_msb_high();
        start(1'b1, 1'b1, 1'b1, 8);
        wait_done(2000);
        check_eq("R7 bit count 8", cap_n, 8);
        check_bits("R2 msb-first", 0, 8, 16'hA5C3, 16'h0F0F, 1'b1);
        check_eq("R8 park high", int'(sclk), 1);
        repeat (8) @(negedge clk);
        check_eq("R8 still high in hold", int'(sclk), 1);
        release_en();
        check_eq("R8 idle rests high", int'(sclk), 1);
    endtask

    task automatic t_loop();
        start(1'b1, 1'b0, 1'b0, 40);
        wait_done(4000);
        check_eq("R7 bit count 40", cap_n, 40);
        check_bits("R3 wrap to stale A", 0, 40, 16'hA5C3, 16'h0F0F, 1'b0);
        release_en();
    endtask

    task automatic t_zero();
        int r0;
        r0 = rises;
        start(1'b1, 1'b0, 1'b0, 0);
        repeat (40) @(negedge clk);
        check_eq("R9 busy never raised", busy_seen, 0);
        check_eq("R9 no clock edges", rises - r0, 0);
        check_eq("R9 clock at rest", int'(sclk), 0);
        release_en();
    endtask

    task automatic t_midload();
        load_word(1'b0, 16'h1234);
        start(1'b1, 1'b0, 1'b0, 48);
        for (int i = 0; i < 500 && cap_n < 4; i++) @(negedge clk);
        load_word(1'b0, 16'hBEEF);
        wait_done(4000);
        check_eq("R10 bit count 48", cap_n, 48);
        check_bits("R10 current word untouched", 0, 32, 16'h1234, 16'h0F0F, 1'b0);
        check_bits("R10 new word on next pass", 32, 16, 16'hBEEF, 16'h0F0F, 1'b0);
        release_en();
    endtask

    task automatic t_free();
        int r0;
        logic s0;
        @(negedge clk);
        fixed_mode = 1'b0;
        msb_first  = 1'b0;
        r0 = rises;
        s0 = sdo;
        repeat (40) @(negedge clk);
        check_eq("R5 free clock runs while idle", int'((rises - r0) >= 9), 1);
        check_eq("R11 sdo quiet while idle", int'(sdo), int'(s0));
        check_eq("R11 busy low while idle", int'(busy), 0);

        start(1'b0, 1'b0, 1'b0, 0);
        for (int i = 0; i < 1000 && cap_n < 20; i++) @(negedge clk);
        @(negedge clk);
        shift_en = 1'b0;
        wait_done(2000);
        check_eq("R6 drain ends at word boundary", cap_n, 32);
        check_bits("R6 drained bits", 0, 32, 16'hBEEF, 16'h0F0F, 1'b0);

        start(1'b0, 1'b1, 1'b0, 0);
        for (int i = 0; i < 1000 && cap_n < 3; i++) @(negedge clk);
        @(negedge clk);
        shift_en = 1'b0;
        wait_done(2000);
        check_eq("R6 stop after first word", cap_n, 16);
        check_bits("R6 restart from A", 0, 16, 16'hBEEF, 16'h0F0F, 1'b1);
        r0 = rises;
        repeat (20) @(negedge clk);
        check_eq("R5 clock runs after stop", int'((rises - r0) >= 4), 1);
    endtask

    // ---------------- main ----------------
    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_fixed_lsb();
        t_fixed_msb_high();
        t_loop();
        t_zero();
        t_midload();
        t_free();
        check_eq("R4 clock moved without tick", tick_viol, 0);
        check_eq("R4 data moved while clock high", sdo_viol, 0);
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        #1200000;
        errs++;
        checks++;
        $display("FAIL watchdog: run incomplete actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

endmodule